// File: doc/BRIEF.md
# Quarter-Wavefront Issue Sequencer

This block runs one instruction for a 64-item wavefront on an array of 16 SIMD lanes, which share a single control path. It accepts an instruction through a valid/ready handshake. It then spends four consecutive clocks on it, handing one quarter of the work items to the lanes in each clock. Each lane holds a four-slot VLIW bundle, so in every clock it can perform up to four independent multiply-add style operations. Each slot works on its own operand triple.

In each issue clock the block drives a quarter index to the context store. The store returns the operand triples for the sixteen items of that quarter in the same clock. The block presents the sixteen lane results on the write-back bus in that same clock, together with the base item index and one write enable per bundle slot. A done pulse marks the final quarter. Instruction fetch and the choice among wavefronts sit outside this block.

Top module: `qws_sequencer`

## Requirements
- R1: After reset, and for as long as reset is held, `instrReady` is 1, and `wbValid`, `instrDone` and `wbSlotWe` are all 0.
- R2: An instruction accepted at a clock edge (`instrValid` and `instrReady` both 1) is issued in exactly four consecutive cycles, starting with the cycle after that edge. `wbValid` is 1 in those cycles, and `rdQuarter` reads 0, 1, 2 and 3 in turn.
- R3: In quarter k, `wbItemBase` equals 16*k. Lane j (the field at bits [j*32 +: 32] of `wbData`, and operands at bits [j*96 +: 96] of `rdOperands`) carries item 16*k+j. Items therefore rise with lane number within a clock.
- R4: `instrDone` is 1 only in the fourth issue cycle of an instruction, for exactly one cycle.
- R5: `instrReady` is 0 in issue quarters 0 to 2, and 1 in quarter 3 and when idle. An instruction accepted at the end of quarter 3 starts quarter 0 in the very next cycle, with no bubble.
- R6: The opcode and the slot enables are captured when the instruction is accepted. Changes on `instrOp` or `instrSlotEn` during execution do not affect that instruction's results or write enables.
- R7: Slot s of a lane takes its operand a at bits [s*24 +: 8], b at [s*24+8 +: 8] and c at [s*24+16 +: 8] within the lane's operand field. It writes its 8-bit result at bits [s*8 +: 8] within the lane's result field. The `instrOp` encoding is: 0 gives a*b+c, 1 gives a*b, 2 gives a+c, 3 gives a*b-c, all modulo 256.
- R8: During issue, `wbSlotWe[s]` equals the captured enable of slot s, and the data of a disabled slot is 0. A destination whose slot is disabled keeps its old value. `wbSlotWe` is 0 whenever `wbValid` is 0.
- R9: `instrValid` asserted while `instrReady` is 0 is ignored; it neither restarts nor extends the running instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction offered |
| instrReady | output | 1 | Instruction can be taken at this edge |
| instrOp | input | 2 | Operation selector (R7 encoding) |
| instrSlotEn | input | 4 | Per-slot enable for the bundle |
| rdQuarter | output | 2 | Quarter index sent to the context store |
| rdOperands | input | 1536 | Operand triples of the 16 items of the quarter |
| wbValid | output | 1 | Write-back bus carries a quarter |
| wbItemBase | output | 6 | Item index handled by lane 0 |
| wbSlotWe | output | 4 | Write enable per bundle slot |
| wbData | output | 512 | Per-lane, per-slot results |
| instrDone | output | 1 | Last quarter of the instruction |

## Verification
The main function is exercised in several ways. A lone all-slot multiply-add with idle gaps around it checks the basic four-clock sweep. A back-to-back stream with `instrValid` held high through execution separates a correct zero-bubble restart from a design that drops or re-accepts instructions. Alternating sparse slot masks with each opcode tell apart slots that are wired to the wrong operand or share the wrong enable. Input changes made while a quarter sweep is running expose opcode or mask leaks from the ports. An all-disabled bundle, followed by a full check of a bench-side destination array, shows that masked destinations are never touched.

// File: rtl/qws_pkg.sv
package qws_pkg;
  localparam int NUM_SLOTS = 4;

  typedef enum logic [1:0] {
    OP_MAD  = 2'd0,
    OP_MUL  = 2'd1,
    OP_ADD  = 2'd2,
    OP_MSUB = 2'd3
  } opSel_e;

  typedef struct packed {
    logic                 issue;
    logic                 last;
    opSel_e               op;
    logic [NUM_SLOTS-1:0] slotEn;
  } qwsStrobe_t;
endpackage

// File: rtl/qws_ctrl.sv
module qws_ctrl
  import qws_pkg::*;
#(
  parameter int QUARTERS = 4,
  parameter int QW       = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instrValid,
  input  opSel_e               instrOp,
  input  logic [NUM_SLOTS-1:0] instrSlotEn,
  output logic                 instrReady,
  output logic [QW-1:0]        quarter,
  output qwsStrobe_t           strobe
);
  localparam logic [QW-1:0] LAST_Q = QW'(QUARTERS - 1);

  logic                 busy;
  logic [QW-1:0]        qCnt;
  opSel_e               opReg;
  logic [NUM_SLOTS-1:0] enReg;
  logic                 lastQ;
  logic                 accept;

  assign lastQ      = busy && (qCnt == LAST_Q);
  assign instrReady = !busy || lastQ;
  assign accept     = instrValid && instrReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      qCnt  <= '0;
      opReg <= OP_MAD;
      enReg <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      qCnt  <= '0;
      opReg <= instrOp;
      enReg <= instrSlotEn;
    end else if (lastQ) begin
      busy  <= 1'b0;
    end else if (busy) begin
      qCnt  <= qCnt + 1'b1;
    end
  end

  assign quarter       = qCnt;
  assign strobe.issue  = busy;
  assign strobe.last   = lastQ;
  assign strobe.op     = opReg;
  assign strobe.slotEn = busy ? enReg : '0;

  AST_QUARTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastQ |=> busy && (qCnt == QW'($past(qCnt) + 1'b1))); // R2
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    lastQ && !instrValid |=> !busy); // R2
  AST_RESTART_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    lastQ && instrValid |=> busy && (qCnt == '0)); // R5
  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastQ |=> $stable(opReg) && $stable(enReg)); // R6
endmodule

// File: rtl/qws_lane.sv
module qws_lane
  import qws_pkg::*;
#(
  parameter int DW = 8
) (
  input  opSel_e                    op,
  input  logic [NUM_SLOTS*3*DW-1:0] operands,
  output logic [NUM_SLOTS*DW-1:0]   results
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [DW-1:0] a, b, c, prod, r;
    assign a    = operands[(3*s)*DW +: DW];
    assign b    = operands[(3*s+1)*DW +: DW];
    assign c    = operands[(3*s+2)*DW +: DW];
    assign prod = a * b;
    always_comb begin
      case (op)
        OP_MAD:  r = prod + c;
        OP_MUL:  r = prod;
        OP_ADD:  r = a + c;
        default: r = prod - c;
      endcase
    end
    assign results[s*DW +: DW] = r;
  end
endmodule

// File: rtl/qws_datapath.sv
module qws_datapath
  import qws_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW    = 8,
  parameter int QW    = 2,
  parameter int LW    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  qwsStrobe_t                    strobe,
  input  logic [QW-1:0]                 quarter,
  input  logic [LANES*NUM_SLOTS*3*DW-1:0] rdOperands,
  output logic                          wbValid,
  output logic [QW+LW-1:0]              wbItemBase,
  output logic [NUM_SLOTS-1:0]          wbSlotWe,
  output logic [LANES*NUM_SLOTS*DW-1:0] wbData
);
  localparam int OPW = NUM_SLOTS * 3 * DW;
  localparam int RW  = NUM_SLOTS * DW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [RW-1:0] laneRes;
    qws_lane #(.DW(DW)) u_lane (
      .op       (strobe.op),
      .operands (rdOperands[l*OPW +: OPW]),
      .results  (laneRes)
    );
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_gate
      assign wbData[l*RW + s*DW +: DW] = strobe.slotEn[s] ? laneRes[s*DW +: DW] : '0;
    end
  end

  assign wbValid    = strobe.issue;
  assign wbSlotWe   = strobe.slotEn;
  assign wbItemBase = {quarter, {LW{1'b0}}};

  AST_WE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !wbValid |-> (wbSlotWe == '0)); // R8
  AST_BASE_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    wbValid && (wbItemBase != '0) |-> $past(wbValid) &&
      (wbItemBase == (QW+LW)'($past(wbItemBase) + LANES))); // R3
endmodule

// File: rtl/qws_sequencer.sv
module qws_sequencer
  import qws_pkg::*;
#(
  parameter int ITEMS = 64,
  parameter int LANES = 16,
  parameter int DW    = 8,
  localparam int QUARTERS = ITEMS / LANES,
  localparam int QW       = $clog2(QUARTERS),
  localparam int LW       = $clog2(LANES),
  localparam int IW       = QW + LW,
  localparam int SLOTS    = NUM_SLOTS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      instrValid,
  output logic                      instrReady,
  input  logic [1:0]                instrOp,
  input  logic [SLOTS-1:0]          instrSlotEn,
  output logic [QW-1:0]             rdQuarter,
  input  logic [LANES*SLOTS*3*DW-1:0] rdOperands,
  output logic                      wbValid,
  output logic [IW-1:0]             wbItemBase,
  output logic [SLOTS-1:0]          wbSlotWe,
  output logic [LANES*SLOTS*DW-1:0] wbData,
  output logic                      instrDone
);
  qwsStrobe_t strobe;
  logic [QW-1:0] quarter;

  qws_ctrl #(.QUARTERS(QUARTERS), .QW(QW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .instrValid  (instrValid),
    .instrOp     (opSel_e'(instrOp)),
    .instrSlotEn (instrSlotEn),
    .instrReady  (instrReady),
    .quarter     (quarter),
    .strobe      (strobe)
  );

  qws_datapath #(.LANES(LANES), .DW(DW), .QW(QW), .LW(LW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .quarter    (quarter),
    .rdOperands (rdOperands),
    .wbValid    (wbValid),
    .wbItemBase (wbItemBase),
    .wbSlotWe   (wbSlotWe),
    .wbData     (wbData)
  );

  assign rdQuarter = quarter;
  assign instrDone = strobe.last;

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |-> wbValid && (rdQuarter == QW'(QUARTERS - 1))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |=> !instrDone); // R4
  AST_NO_EARLY_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    wbValid && !instrDone |-> !instrReady); // R5
  AST_REJECT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && !instrReady |=> wbValid && (rdQuarter == QW'($past(rdQuarter) + 1'b1))); // R9
endmodule

// File: tb/qws_sequencer_tb.sv
module qws_sequencer_tb;
  localparam int ITEMS = 64, LANES = 16, DW = 8, SLOTS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0;
  logic [1:0] instrOp = 2'd0;
  logic [3:0] instrSlotEn = 4'd0;
  logic instrReady, wbValid, instrDone;
  logic [1:0] rdQuarter;
  logic [5:0] wbItemBase;
  logic [3:0] wbSlotWe;
  logic [LANES*SLOTS*3*DW-1:0] rdOperands;
  logic [LANES*SLOTS*DW-1:0] wbData;

  int checks = 0, fails = 0;
  int curInstr = 0;
  bit finished = 0;
  bit mBusy = 0;
  int mQ = 0, mOp = 0, mEn = 0;
  logic [7:0] dest [ITEMS][SLOTS];
  logic [7:0] destExp [ITEMS][SLOTS];

  always #4 clk = ~clk;

  qws_sequencer u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrReady(instrReady),
    .instrOp(instrOp), .instrSlotEn(instrSlotEn), .rdQuarter(rdQuarter),
    .rdOperands(rdOperands), .wbValid(wbValid), .wbItemBase(wbItemBase),
    .wbSlotWe(wbSlotWe), .wbData(wbData), .instrDone(instrDone)
  );

  function automatic logic [7:0] opnd(int item, int slot, int which, int inst);
    return 8'((item * 7 + slot * 29 + which * 53 + inst * 11 + 3) & 255);
  endfunction

  function automatic logic [7:0] refCalc(int op, int a, int b, int c);
    case (op)
      0: return 8'((a * b + c) & 255);
      1: return 8'((a * b) & 255);
      2: return 8'((a + c) & 255);
      default: return 8'((a * b - c) & 255);
    endcase
  endfunction

  // context store: answers the quarter index in the same cycle (R3, R7 packing)
  always_comb begin
    for (int j = 0; j < LANES; j++)
      for (int s = 0; s < SLOTS; s++)
        for (int w = 0; w < 3; w++)
          rdOperands[(j*SLOTS*3 + s*3 + w)*DW +: DW] =
            opnd(int'(rdQuarter) * LANES + j, s, w, curInstr);
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference sequencer, advanced on the edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mQ = 0; mOp = 0; mEn = 0;
    end else begin
      bit rdy;
      rdy = !mBusy || (mQ == 3);
      if (instrValid && rdy) begin
        mBusy = 1; mQ = 0; mOp = int'(instrOp); mEn = int'(instrSlotEn);
        curInstr++;
      end else if (mBusy && mQ == 3) mBusy = 0;
      else if (mBusy) mQ++;
    end
  end

  // per-cycle comparison and destination update, away from the edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R5 R9 ready", 64'(instrReady), 64'(!mBusy || mQ == 3));
      check("R2 valid", 64'(wbValid), 64'(mBusy));
      check("R4 done", 64'(instrDone), 64'(mBusy && mQ == 3));
      check("R8 R6 slot write enables", 64'(wbSlotWe), mBusy ? 64'(mEn) : 64'd0);
      if (mBusy) begin
        check("R2 quarter", 64'(rdQuarter), 64'(mQ));
        check("R3 item base", 64'(wbItemBase), 64'(mQ * LANES));
        for (int j = 0; j < LANES; j++)
          for (int s = 0; s < SLOTS; s++) begin
            int it;
            logic [7:0] e;
            it = mQ * LANES + j;
            e = mEn[s] ? refCalc(mOp, opnd(it, s, 0, curInstr), opnd(it, s, 1, curInstr),
                                 opnd(it, s, 2, curInstr)) : 8'd0;
            check("R7 R6 R8 lane result", 64'(wbData[(j*SLOTS + s)*DW +: DW]), 64'(e));
            if (mEn[s]) destExp[it][s] = e;
            if (wbValid && wbSlotWe[s])
              dest[int'(wbItemBase) + j][s] = wbData[(j*SLOTS + s)*DW +: DW];
          end
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [3:0] en);
    instrValid = 1'b1; instrOp = op; instrSlotEn = en;
    while (!instrReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [1:0] op, input logic [3:0] en);
    instrValid = 1'b0; instrOp = op; instrSlotEn = en;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    for (int i = 0; i < ITEMS; i++)
      for (int s = 0; s < SLOTS; s++) begin
        dest[i][s] = 8'(8'hC3 ^ i ^ (s << 6));
        destExp[i][s] = 8'(8'hC3 ^ i ^ (s << 6));
      end
    repeat (3) @(negedge clk);
    // R1 while reset is held
    check("R1 ready in reset", 64'(instrReady), 64'd1);
    check("R1 valid in reset", 64'(wbValid), 64'd0);
    check("R1 done in reset", 64'(instrDone), 64'd0);
    check("R1 we in reset", 64'(wbSlotWe), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 64'(instrReady), 64'd1);
    check("R1 valid after reset", 64'(wbValid), 64'd0);

    // lone multiply-add, all slots
    issue(2'd0, 4'hF);
    idle(5, 2'd0, 4'hF);
    // back-to-back stream, valid held through execution (R5, R9)
    issue(2'd1, 4'b1010);
    issue(2'd2, 4'b0101);
    issue(2'd3, 4'hF);
    issue(2'd0, 4'b1000);
    idle(2, 2'd0, 4'd0);
    // inputs changed during execution (R6)
    issue(2'd2, 4'b0011);
    idle(1, 2'd3, 4'hC);
    idle(1, 2'd1, 4'hF);
    idle(4, 2'd0, 4'h0);
    // fully disabled bundle (R8)
    issue(2'd3, 4'b0000);
    idle(6, 2'd1, 4'hF);
    // odd mask with subtract
    issue(2'd3, 4'b0110);
    idle(6, 2'd0, 4'h0);

    finished = 1;
    // R8: masked destinations never touched, enabled ones hold the last result
    for (int i = 0; i < ITEMS; i++)
      for (int s = 0; s < SLOTS; s++)
        check("R8 destination", 64'(dest[i][s]), 64'(destExp[i][s]));
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule